// File: doc/BRIEF.md
# Video Active-Region Timing Meter

This block measures the raster geometry of an incoming picture. It runs on the pixel clock and watches the horizontal and vertical sync pulses, a horizontal flyback pulse and a set of per-channel video-detect bits. The detect bits are merged into one activity flag. On each axis the block reports the sync pulse width, the back porch, the active video span and the front porch. Horizontal figures are in pixel clocks and vertical figures are in lines.

Measurements accumulate over a whole field. Horizontally, the block keeps the smallest back porch and the smallest front porch over all lines that carry video, and it reports the span between the outermost active pixels of the field. Vertically, it reports the first and last lines that carry video. When the next vertical sync pulse begins, the results of the field are latched into the output fields and a one-cycle strobe is raised. Firmware can read the latched figures at any later time to size the picture.

Top module: `video_raster_meter`

## Requirements
- R1: The activity flag is the OR of all detect bits, so any single channel alone produces a full measurement.
- R2: `h_sync_w` is the number of clocks the horizontal reference was high in its most recent completed pulse. `v_sync_w` is the number of `hsync` rising edges seen while `vsync` was high in the most recent vertical pulse.
- R3: Pixel positions are numbered from 0 at the first clock after the horizontal reference falls. `h_bp` is the smallest position of the first active pixel, taken over the lines of the field.
- R4: `h_fp` is the smallest count, taken over the lines of the field, of inactive low clocks between a line's last active pixel and the next rising edge of the reference.
- R5: `h_act` equals the largest active position minus the smallest first-active position, plus one, across the field.
- R6: Vertical line indices start at 0 at the falling edge of `vsync`. Each `hsync` rising edge closes one line, and activity seen after the final closed line is not counted. `v_bp` is the index of the first line with activity. `v_act` is last index minus first index plus one. `v_fp` is the number of closed lines after the last line with activity.
- R7: `ref_sel` = 0 selects `hsync` as the horizontal reference and `ref_sel` = 1 selects `flyback`. The vertical figures always use `hsync` and do not depend on `ref_sel`.
- R8: A line without activity changes none of the horizontal minimums. A field without activity reports all-ones in `h_bp`, `h_fp`, `v_bp` and `v_fp`, and zero in `h_act` and `v_act`.
- R9: At each `vsync` rising edge the block latches the current figures and pulses `res_valid` high for exactly one cycle, in the cycle after that edge is sampled. The field accumulators then restart.
- R10: All counters are 12 bits wide (parameter `CW`) and stick at all-ones instead of wrapping.
- R11: After reset, all result fields are zero and `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| flyback | input | 1 | Horizontal flyback pulse, active high |
| det | input | NCH | Per-channel video-detect bits |
| ref_sel | input | 1 | Horizontal reference: 0 selects hsync, 1 selects flyback |
| h_sync_w | output | CW | Horizontal reference pulse width |
| h_bp | output | CW | Minimum horizontal back porch |
| h_act | output | CW | Horizontal active span |
| h_fp | output | CW | Minimum horizontal front porch |
| v_sync_w | output | CW | Vertical sync width in lines |
| v_bp | output | CW | Vertical back porch in lines |
| v_act | output | CW | Vertical active span in lines |
| v_fp | output | CW | Vertical front porch in lines |
| res_valid | output | 1 | One-cycle strobe when new results are latched |

## Verification
The stimulus is chosen so that no single line contains the widest span. One line starts early and another ends late. A design that measured only one line would report a span that is too narrow, or porches that are too wide.

A field driven with the flyback reference shifts the horizontal width and back porch but leaves the vertical figures unchanged. A design that mixed up the two references would miss this. A field with no video must give all-ones porches; a design that let idle lines update the minimums would report small false values instead. A line longer than 4096 clocks would expose a counter that wraps, because the back porch would come out small rather than stuck at 4095.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
   localparam int unsigned VRM_CW_DEF = 12;

   typedef enum logic {
      REF_HSYNC   = 1'b0,
      REF_FLYBACK = 1'b1
   } ref_src_e;
endpackage

// File: rtl/vrm_hmeter.sv
module vrm_hmeter #(
   parameter int unsigned CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          href,
   input  logic          act,
   input  logic          fld_end,
   output logic [CW-1:0] o_sw,
   output logic [CW-1:0] o_bp,
   output logic [CW-1:0] o_act,
   output logic [CW-1:0] o_fp
);
   localparam logic [CW-1:0] ALL1 = '1;
   localparam logic [CW-1:0] ONE  = CW'(1);

   function automatic logic [CW-1:0] inc_sat(input logic [CW-1:0] v);
      return (v == ALL1) ? v : v + ONE;
   endfunction

   logic          href_q, seen, any_q;
   logic [CW-1:0] hi_cnt, sw_q, pos, fp_run, min_bp, min_fp, max_last;
   logic          fall, rise, seen_c;
   logic [CW-1:0] pos_c, fpr_c;
   logic [CW:0]   span;

   assign fall   = !href && href_q;
   assign rise   = href && !href_q;
   assign pos_c  = fall ? '0 : pos;
   assign seen_c = fall ? 1'b0 : seen;
   assign fpr_c  = fall ? '0 : fp_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         href_q   <= 1'b0;
         seen     <= 1'b0;
         any_q    <= 1'b0;
         hi_cnt   <= '0;
         sw_q     <= '0;
         pos      <= '0;
         fp_run   <= '0;
         min_bp   <= ALL1;
         min_fp   <= ALL1;
         max_last <= '0;
      end else begin
         href_q <= href;
         if (href) hi_cnt <= href_q ? inc_sat(hi_cnt) : ONE;
         if (fall) sw_q <= hi_cnt;
         if (!href) begin
            pos <= inc_sat(pos_c);
            if (act) begin
               seen   <= 1'b1;
               any_q  <= 1'b1;
               fp_run <= '0;
               if (!seen_c && pos_c < min_bp) min_bp <= pos_c;
               if (pos_c > max_last) max_last <= pos_c;
            end else begin
               seen   <= seen_c;
               fp_run <= inc_sat(fpr_c);
            end
         end
         if (rise && seen && any_q && fp_run < min_fp) min_fp <= fp_run;
         if (fld_end) begin
            min_bp   <= ALL1;
            min_fp   <= ALL1;
            max_last <= '0;
            any_q    <= 1'b0;
         end
      end
   end

   assign span  = {1'b0, max_last} - {1'b0, min_bp} + {{CW{1'b0}}, 1'b1};
   assign o_sw  = sw_q;
   assign o_bp  = min_bp;
   assign o_fp  = min_fp;
   assign o_act = !any_q ? '0 : (span[CW] ? ALL1 : span[CW-1:0]);

   assert_minbp_mono_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !fld_end |=> (min_bp <= $past(min_bp)));
   assert_minfp_mono_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !fld_end |=> (min_fp <= $past(min_fp)));
   assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (href && href_q) |=> (hi_cnt >= $past(hi_cnt)));
endmodule

// File: rtl/vrm_vmeter.sv
module vrm_vmeter #(
   parameter int unsigned CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vsync,
   input  logic          hsync,
   input  logic          act,
   output logic          o_fld_end,
   output logic [CW-1:0] o_sw,
   output logic [CW-1:0] o_bp,
   output logic [CW-1:0] o_act,
   output logic [CW-1:0] o_fp
);
   localparam logic [CW-1:0] ALL1 = '1;
   localparam logic [CW-1:0] ONE  = CW'(1);

   function automatic logic [CW-1:0] inc_sat(input logic [CW-1:0] v);
      return (v == ALL1) ? v : v + ONE;
   endfunction

   logic          vs_q, hs_q, la, vseen;
   logic [CW-1:0] vcnt, sw_q, vline, vfpr, vfirst, vlast;
   logic          vrise, vfall, hrise, la_c;
   logic [CW-1:0] vline_c, fpr_c;
   logic [CW:0]   span;

   assign vrise   = vsync && !vs_q;
   assign vfall   = !vsync && vs_q;
   assign hrise   = hsync && !hs_q;
   assign vline_c = vfall ? '0 : vline;
   assign fpr_c   = vfall ? '0 : vfpr;
   assign la_c    = (vfall ? 1'b0 : la) | act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vs_q   <= 1'b0;
         hs_q   <= 1'b0;
         la     <= 1'b0;
         vseen  <= 1'b0;
         vcnt   <= '0;
         sw_q   <= '0;
         vline  <= '0;
         vfpr   <= '0;
         vfirst <= '0;
         vlast  <= '0;
      end else begin
         vs_q <= vsync;
         hs_q <= hsync;
         if (vsync) begin
            if (vrise) begin
               vcnt  <= hrise ? ONE : '0;
               vseen <= 1'b0;
            end else if (hrise) begin
               vcnt <= inc_sat(vcnt);
            end
         end else begin
            if (vfall) sw_q <= vcnt;
            if (hrise) begin
               if (la_c) begin
                  if (!vseen) begin
                     vfirst <= vline_c;
                     vseen  <= 1'b1;
                  end
                  vlast <= vline_c;
                  vfpr  <= '0;
               end else begin
                  vfpr <= inc_sat(fpr_c);
               end
               vline <= inc_sat(vline_c);
               la    <= 1'b0;
            end else begin
               la    <= la_c;
               vline <= vline_c;
               vfpr  <= fpr_c;
            end
         end
      end
   end

   assign span      = {1'b0, vlast} - {1'b0, vfirst} + {{CW{1'b0}}, 1'b1};
   assign o_fld_end = vrise;
   assign o_sw      = sw_q;
   assign o_bp      = vseen ? vfirst : ALL1;
   assign o_fp      = vseen ? vfpr : ALL1;
   assign o_act     = !vseen ? '0 : (span[CW] ? ALL1 : span[CW-1:0]);

   assert_line_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vseen |-> (vlast >= vfirst));
   assert_sync_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && vs_q && !hrise) |=> (vcnt == $past(vcnt)));
endmodule

// File: rtl/video_raster_meter.sv
module video_raster_meter
   import vrm_pkg::*;
#(
   parameter int unsigned CW  = VRM_CW_DEF,
   parameter int unsigned NCH = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hsync,
   input  logic           vsync,
   input  logic           flyback,
   input  logic [NCH-1:0] det,
   input  logic           ref_sel,
   output logic [CW-1:0]  h_sync_w,
   output logic [CW-1:0]  h_bp,
   output logic [CW-1:0]  h_act,
   output logic [CW-1:0]  h_fp,
   output logic [CW-1:0]  v_sync_w,
   output logic [CW-1:0]  v_bp,
   output logic [CW-1:0]  v_act,
   output logic [CW-1:0]  v_fp,
   output logic           res_valid
);
   if (CW < 2 || CW > 31) begin : g_bad_cw
      $error("video_raster_meter: CW must lie in 2..31");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("video_raster_meter: NCH must be at least 1");
   end

   logic [NCH:0] or_chain;
   assign or_chain[0] = 1'b0;
   for (genvar i = 0; i < NCH; i++) begin : g_or
      assign or_chain[i+1] = or_chain[i] | det[i];
   end

   logic     act, href, fld_end;
   ref_src_e src;
   assign act  = or_chain[NCH];
   assign src  = ref_src_e'(ref_sel);
   assign href = (src == REF_FLYBACK) ? flyback : hsync;

   logic [CW-1:0] hsw_l, hbp_l, hact_l, hfp_l, vsw_l, vbp_l, vact_l, vfp_l;

   vrm_hmeter #(.CW(CW)) u_h (
      .clk(clk), .rst_n(rst_n), .href(href), .act(act), .fld_end(fld_end),
      .o_sw(hsw_l), .o_bp(hbp_l), .o_act(hact_l), .o_fp(hfp_l)
   );

   vrm_vmeter #(.CW(CW)) u_v (
      .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync), .act(act),
      .o_fld_end(fld_end),
      .o_sw(vsw_l), .o_bp(vbp_l), .o_act(vact_l), .o_fp(vfp_l)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         h_sync_w  <= '0;
         h_bp      <= '0;
         h_act     <= '0;
         h_fp      <= '0;
         v_sync_w  <= '0;
         v_bp      <= '0;
         v_act     <= '0;
         v_fp      <= '0;
      end else begin
         res_valid <= fld_end;
         if (fld_end) begin
            h_sync_w <= hsw_l;
            h_bp     <= hbp_l;
            h_act    <= hact_l;
            h_fp     <= hfp_l;
            v_sync_w <= vsw_l;
            v_bp     <= vbp_l;
            v_act    <= vact_l;
            v_fp     <= vfp_l;
         end
      end
   end

   assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !fld_end |=> $stable(h_bp) && $stable(v_act));
   assert_idle_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && h_act == '0) |-> (h_bp == '1 && h_fp == '1));
endmodule

// File: tb/tb_video_raster_meter.sv
module tb_video_raster_meter;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hs = 1'b0, vs = 1'b0, fb = 1'b0, rsel = 1'b0;
   logic [2:0] det = 3'b000;
   logic [11:0] h_sync_w, h_bp, h_act, h_fp, v_sync_w, v_bp, v_act, v_fp;
   logic res_valid;

   always #5 clk = ~clk;

   video_raster_meter dut (
      .clk(clk), .rst_n(rst_n), .hsync(hs), .vsync(vs), .flyback(fb),
      .det(det), .ref_sel(rsel),
      .h_sync_w(h_sync_w), .h_bp(h_bp), .h_act(h_act), .h_fp(h_fp),
      .v_sync_w(v_sync_w), .v_bp(v_bp), .v_act(v_act), .v_fp(v_fp),
      .res_valid(res_valid)
   );

   int total = 0, fails = 0;

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic int sat(input int x);
      return (x > 4095) ? 4095 : x;
   endfunction

   // behavioural reference model
   int m_hi, m_hsw, m_pos, m_fpr, m_minbp, m_minfp, m_maxlast;
   bit m_hq, m_seen, m_any;
   int m_vcnt, m_vsw, m_vline, m_vfpr, m_vfirst, m_vlast;
   bit m_vsq, m_hsq, m_la, m_vseen;
   int e_hsw, e_hbp, e_hact, e_hfp, e_vsw, e_vbp, e_vact, e_vfp;
   bit e_valid;
   bit a, hr, vrise, hsr, la;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_hi = 0; m_hsw = 0; m_pos = 0; m_fpr = 0; m_minbp = 4095; m_minfp = 4095;
         m_maxlast = 0; m_hq = 0; m_seen = 0; m_any = 0;
         m_vcnt = 0; m_vsw = 0; m_vline = 0; m_vfpr = 0; m_vfirst = 0; m_vlast = 0;
         m_vsq = 0; m_hsq = 0; m_la = 0; m_vseen = 0;
         e_hsw = 0; e_hbp = 0; e_hact = 0; e_hfp = 0;
         e_vsw = 0; e_vbp = 0; e_vact = 0; e_vfp = 0; e_valid = 0;
      end else begin
         a = |det;
         hr = rsel ? fb : hs;
         vrise = vs && !m_vsq;
         hsr = hs && !m_hsq;
         e_valid = vrise;
         if (vrise) begin
            e_hsw = m_hsw; e_hbp = m_minbp; e_hfp = m_minfp;
            e_hact = m_any ? sat(m_maxlast - m_minbp + 1) : 0;
            e_vsw = m_vsw;
            e_vbp = m_vseen ? m_vfirst : 4095;
            e_vact = m_vseen ? sat(m_vlast - m_vfirst + 1) : 0;
            e_vfp = m_vseen ? m_vfpr : 4095;
         end
         if (hr) m_hi = m_hq ? sat(m_hi + 1) : 1;
         else begin
            if (m_hq) begin m_hsw = m_hi; m_pos = 0; m_seen = 0; m_fpr = 0; end
            if (a) begin
               if (!m_seen && m_pos < m_minbp) m_minbp = m_pos;
               if (m_pos > m_maxlast) m_maxlast = m_pos;
               m_seen = 1; m_any = 1; m_fpr = 0;
            end else m_fpr = sat(m_fpr + 1);
            m_pos = sat(m_pos + 1);
         end
         if (hr && !m_hq && m_seen && m_any && m_fpr < m_minfp) m_minfp = m_fpr;
         if (vrise) begin m_minbp = 4095; m_minfp = 4095; m_maxlast = 0; m_any = 0; end
         m_hq = hr;
         if (vs) begin
            if (vrise) begin m_vcnt = hsr ? 1 : 0; m_vseen = 0; end
            else if (hsr) m_vcnt = sat(m_vcnt + 1);
         end else begin
            if (m_vsq) begin m_vsw = m_vcnt; m_vline = 0; m_la = 0; m_vfpr = 0; end
            la = m_la | a;
            if (hsr) begin
               if (la) begin
                  if (!m_vseen) begin m_vfirst = m_vline; m_vseen = 1; end
                  m_vlast = m_vline; m_vfpr = 0;
               end else m_vfpr = sat(m_vfpr + 1);
               m_vline = sat(m_vline + 1);
               m_la = 0;
            end else m_la = la;
         end
         m_vsq = vs;
         m_hsq = hs;
      end
   end

   int s_hsw, s_hbp, s_hact, s_hfp, s_vsw, s_vbp, s_vact, s_vfp;

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R9 res_valid", int'(res_valid), int'(e_valid));
         chk("R2 h_sync_w", int'(h_sync_w), e_hsw);
         chk("R3 h_bp", int'(h_bp), e_hbp);
         chk("R5 h_act", int'(h_act), e_hact);
         chk("R4 h_fp", int'(h_fp), e_hfp);
         chk("R2 v_sync_w", int'(v_sync_w), e_vsw);
         chk("R6 v_bp", int'(v_bp), e_vbp);
         chk("R6 v_act", int'(v_act), e_vact);
         chk("R6 v_fp", int'(v_fp), e_vfp);
         if (res_valid) begin
            s_hsw = h_sync_w; s_hbp = h_bp; s_hact = h_act; s_hfp = h_fp;
            s_vsw = v_sync_w; s_vbp = v_bp; s_vact = v_act; s_vfp = v_fp;
         end
      end
   end

   task automatic run_line(input int sw, input int len, input int a0, input int a1,
                           input logic [2:0] ch, input int vset);
      for (int c = 0; c < sw + len; c++) begin
         @(negedge clk);
         hs = (c < sw);
         fb = (c < sw + 3);
         det = (a0 >= 0 && c >= sw + a0 && c <= sw + a1) ? ch : 3'b000;
         if (c == sw && vset >= 0) vs = vset[0];
      end
   endtask

   task automatic run_field(input bit rs, input int sw, input int len, input int nvs,
                            input int nl, input int va0, input int va1, input int a0,
                            input int a1, input logic [2:0] ch, input bit vid);
      rsel = rs;
      for (int i = 0; i < nvs + nl; i++) begin
         int vset, b0, b1;
         vset = (i == 0) ? 1 : ((i == nvs) ? 0 : -1);
         if (!vid || i < va0 || i > va1) begin b0 = -1; b1 = -1; end
         else if (i == va0) begin b0 = a0 + 5; b1 = a1; end
         else if (i == va0 + 1) begin b0 = a0; b1 = a1 - 5; end
         else begin b0 = a0 + 5; b1 = a1 - 5; end
         run_line(sw, len, b0, b1, ch, vset);
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 res_valid after reset", int'(res_valid), 0);
      chk("R11 h_bp after reset", int'(h_bp), 0);
      chk("R11 v_fp after reset", int'(v_fp), 0);

      run_field(0, 4, 40, 2, 8, 4, 7, 8, 30, 3'b001, 1);   // A
      run_field(1, 4, 40, 2, 8, 4, 7, 8, 30, 3'b010, 1);   // B, reports A
      chk("R2 h_sync_w hsync ref", s_hsw, 4);
      chk("R3 h_bp outermost", s_hbp, 8);
      chk("R4 h_fp minimum", s_hfp, 9);
      chk("R5 h_act span over lines", s_hact, 23);
      chk("R2 v_sync_w", s_vsw, 2);
      chk("R6 v_bp", s_vbp, 2);
      chk("R6 v_act", s_vact, 4);
      chk("R6 v_fp", s_vfp, 2);

      run_field(0, 4, 40, 2, 8, 4, 7, 8, 30, 3'b100, 1);   // C, reports B
      chk("R7 h_sync_w flyback ref", s_hsw, 7);
      chk("R7 h_bp flyback ref", s_hbp, 5);
      chk("R7 h_fp flyback ref", s_hfp, 9);
      chk("R7 v_sync_w independent of ref", s_vsw, 2);
      chk("R7 v_act independent of ref", s_vact, 4);

      run_field(0, 4, 40, 2, 8, 4, 7, 8, 30, 3'b001, 0);   // D, reports C
      chk("R1 h_act single channel 2", s_hact, 23);
      chk("R1 v_act single channel 2", s_vact, 4);

      run_field(0, 4, 5000, 1, 3, 1, 2, 4500, 4600, 3'b001, 1); // E, reports D
      chk("R8 h_bp idle field", s_hbp, 4095);
      chk("R8 h_fp idle field", s_hfp, 4095);
      chk("R8 h_act idle field", s_hact, 0);
      chk("R8 v_bp idle field", s_vbp, 4095);
      chk("R8 v_act idle field", s_vact, 0);
      chk("R8 v_fp idle field", s_vfp, 4095);

      run_field(0, 4, 40, 2, 8, 4, 7, 8, 30, 3'b011, 1);   // F, reports E
      chk("R10 h_bp saturates", s_hbp, 4095);
      chk("R10 h_act saturated span", s_hact, 1);
      chk("R10 h_fp unsaturated", s_hfp, 399);
      chk("R10 v_act long lines", s_vact, 2);
      chk("R10 v_fp long lines", s_vfp, 1);

      repeat (5) @(negedge clk);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule